// File: doc/BRIEF.md
# Hamming Sector ECC Corrector

This block checks one 512-byte sector that is protected by a 24-bit Hamming code able to correct a single bit. On a start strobe it takes two 24-bit ECC values. One is the code stored in the spare area. The other is the code computed over the sector as it was read back.

Both values are packed into a 32-bit layout and combined by XOR into a syndrome. The syndrome is then sorted into one of five outcomes: clean, correctable data error, corrupted ECC, erased page, or uncorrectable. For a correctable error the block reports the byte and the bit that are wrong. It can also invert that bit in a local sector buffer, which the host loads and reads back through a simple byte port.

Computing the ECC over the data stream is done elsewhere.

Top module: `ham_sector_fix`

## Requirements
- R1: Each 24-bit ECC input holds byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. It is packed as {4'h0, byte2[7:4], byte1, 4'h0, byte2[3:0], byte0}. The syndrome is the XOR of the packed stored and packed computed values. A zero syndrome gives result code 0 (clean).
- R2: A syndrome with exactly 12 bits set gives result code 1 (correctable). err_byte then equals syndrome bits 27:19 and err_bit equals syndrome bits 18:16.
- R3: A syndrome with exactly one bit set gives result code 2 (ECC corrupted), and the sector buffer is left unchanged.
- R4: A stored input of 24'hFFFFFF (packed 0x0FFF0FFF) together with a computed input of zero gives result code 3 (erased page).
- R5: Any other non-zero syndrome gives result code 4 (uncorrectable).
- R6: done is high for exactly the cycle after each cycle in which start is high. result, err_byte and err_bit keep their values until the next start.
- R7: If start comes with apply_fix high and the result is code 1, the buffer byte at err_byte has bit err_bit inverted when done rises. With apply_fix low, or with any other code, the buffer is not changed.
- R8: A buffer write with buf_we stores buf_wdata at buf_addr. buf_rdata returns the byte at buf_addr one cycle after the address is presented.
- R9: While rst_n is low, done, result, err_byte and err_bit are all zero. err_byte and err_bit are also zero after any result other than code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one check |
| apply_fix | input | 1 | Correct the buffer when the error is correctable |
| ecc_stored | input | 24 | ECC read from the spare area |
| ecc_calc | input | 24 | ECC computed over the data |
| buf_we | input | 1 | Buffer byte write enable |
| buf_addr | input | 9 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle latency |
| done | output | 1 | Result valid pulse |
| result | output | 3 | Outcome code |
| err_byte | output | 9 | Byte index of the error |
| err_bit | output | 3 | Bit index of the error |

## Verification
The assertions assume that the host never asserts buf_we in a cycle with start. The bench keeps to this by driving buffer writes and checks in separate cycles.

The assertions also take every start as a fresh request, held for one cycle only. The bench pulses start for a single cycle and releases it before it samples done.

Correctable vectors are built from a chosen byte and bit. The lower syndrome half is set to the complement of the upper half, which gives a weight of exactly 12 and so stays inside the class the block corrects.

// File: rtl/ham_sector_fix.sv
module ham_sector_fix #(
  parameter int SECT_BYTES = 512,
  parameter int ECC_W      = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  apply_fix,
  input  logic [ECC_W-1:0]      ecc_stored,
  input  logic [ECC_W-1:0]      ecc_calc,
  input  logic                  buf_we,
  input  logic [8:0]            buf_addr,
  input  logic [7:0]            buf_wdata,
  output logic [7:0]            buf_rdata,
  output logic                  done,
  output logic [2:0]            result,
  output logic [8:0]            err_byte,
  output logic [2:0]            err_bit
);
  localparam logic [2:0] RES_CLEAN   = 3'd0;
  localparam logic [2:0] RES_FIXABLE = 3'd1;
  localparam logic [2:0] RES_ECCBAD  = 3'd2;
  localparam logic [2:0] RES_ERASED  = 3'd3;
  localparam logic [2:0] RES_MULTI   = 3'd4;
  localparam logic [31:0] BLANK_PACK = 32'h0FFF_0FFF;

  function automatic logic [31:0] pack24(input logic [ECC_W-1:0] v);
    return {4'h0, v[23:20], v[15:8], 4'h0, v[19:16], v[7:0]};
  endfunction

  function automatic logic [5:0] weight32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
    return n;
  endfunction

  logic [31:0] p_st, p_cl, syn;
  logic [5:0]  syn_w;
  logic [2:0]  cls;
  logic [8:0]  loc_byte;
  logic [2:0]  loc_bit;
  logic        fixable;

  assign p_st     = pack24(ecc_stored);
  assign p_cl     = pack24(ecc_calc);
  assign syn      = p_st ^ p_cl;
  assign syn_w    = weight32(syn);
  assign loc_byte = syn[27:19];
  assign loc_bit  = syn[18:16];
  assign fixable  = (syn_w == 6'd12);

  always_comb begin
    if (syn == 32'd0)                              cls = RES_CLEAN;
    else if (fixable)                              cls = RES_FIXABLE;
    else if (syn_w == 6'd1)                        cls = RES_ECCBAD;
    else if (p_st == BLANK_PACK && p_cl == 32'd0)  cls = RES_ERASED;
    else                                           cls = RES_MULTI;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      result   <= RES_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      done <= start;
      if (start) begin
        result   <= cls;
        err_byte <= fixable ? loc_byte : 9'd0;
        err_bit  <= fixable ? loc_bit  : 3'd0;
      end
    end
  end

  logic [7:0] sect_mem [SECT_BYTES];

  always_ff @(posedge clk) begin
    if (start && apply_fix && fixable)
      sect_mem[loc_byte] <= sect_mem[loc_byte] ^ (8'd1 << loc_bit);
    else if (buf_we)
      sect_mem[buf_addr] <= buf_wdata;
    buf_rdata <= sect_mem[buf_addr];
  end
endmodule

module ham_sector_fix_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        buf_we,
  input logic [23:0] ecc_stored,
  input logic [23:0] ecc_calc,
  input logic        done,
  input logic [2:0]  result,
  input logic [8:0]  err_byte,
  input logic [2:0]  err_bit
);
  a_r6_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result) && $stable(err_byte) && $stable(err_bit));
  a_r1_equal_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ecc_stored == ecc_calc) |=> result == 3'd0);
  a_r4_blank_is_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ecc_stored == 24'hFFFFFF && ecc_calc == 24'h0) |=> result == 3'd3);
  a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result <= 3'd4);
  a_r9_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 3'd1) |-> (err_byte == 9'd0 && err_bit == 3'd0));
  a_r7_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && buf_we));
endmodule

bind ham_sector_fix ham_sector_fix_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .buf_we(buf_we),
  .ecc_stored(ecc_stored), .ecc_calc(ecc_calc), .done(done),
  .result(result), .err_byte(err_byte), .err_bit(err_bit)
);

// File: tb/ham_sector_fix_tb.sv
module ham_sector_fix_tb_top;
  logic clk = 0, rst_n = 0, start = 0, apply_fix = 0, buf_we = 0;
  logic [23:0] ecc_stored = '0, ecc_calc = '0;
  logic [8:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic done;
  logic [2:0] result, err_bit;
  logic [8:0] err_byte;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ham_sector_fix dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .apply_fix(apply_fix),
    .ecc_stored(ecc_stored), .ecc_calc(ecc_calc), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done(done), .result(result), .err_byte(err_byte), .err_bit(err_bit));

  // {stored, calc, code, byte, bit}
  localparam int NV = 9;
  localparam logic [62:0] VEC [NV] = '{
    {24'h123456, 24'h123456, 3'd0, 9'd0,   3'd0},  // R1
    {24'hFFFFFF, 24'h000000, 3'd3, 9'd0,   3'd0},  // R4
    {24'h000001, 24'h000000, 3'd2, 9'd0,   3'd0},  // R3
    {24'h100000, 24'h000000, 3'd2, 9'd0,   3'd0},  // R3 high nibble of byte2
    {24'h000003, 24'h000000, 3'd4, 9'd0,   3'd0},  // R5
    {24'hFFFFFF, 24'h000001, 3'd4, 9'd0,   3'd0},  // R5 not erased
    {24'h0F00FF, 24'h000000, 3'd1, 9'd0,   3'd0},  // R2
    {24'hABCDEF, 24'h5B32EF, 3'd1, 9'd511, 3'd7},  // R2
    {24'h5A2BD4, 24'h000000, 3'd1, 9'd165, 3'd3}   // R2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] s, input logic [23:0] c, input bit fix);
    @(negedge clk);
    ecc_stored = s; ecc_calc = c; apply_fix = fix; start = 1;
    @(negedge clk);
    start = 0; apply_fix = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1; buf_addr = a[8:0]; buf_wdata = d;
    @(negedge clk);
    buf_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    buf_addr = a[8:0];
    @(negedge clk);
    d = buf_rdata;
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    chk(done == 0 && result == 0 && err_byte == 0 && err_bit == 0, "R9 reset", {done, result}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][62:39], VEC[i][38:15], 0);
      chk(done == 1, "R6 done", done, 1);
      chk(result == VEC[i][14:12], "R1-5 code", result, VEC[i][14:12]);
      chk(err_byte == VEC[i][11:3] && err_bit == VEC[i][2:0], "R2/R9 location",
          {err_byte, err_bit}, VEC[i][11:0]);
    end

    // R6: one-cycle pulse and hold
    @(negedge clk);
    chk(done == 0, "R6 pulse width", done, 0);
    repeat (3) @(negedge clk);
    chk(result == 3'd1 && err_byte == 9'd165, "R6 hold", {result, err_byte}, {3'd1, 9'd165});

    // R8 buffer write/read
    wr(165, 8'h00); wr(164, 8'h77); wr(0, 8'h3C);
    rd(164, rv); chk(rv == 8'h77, "R8 readback", rv, 8'h77);

    // R7 apply fix
    run(24'h5A2BD4, 24'h0, 1);
    rd(165, rv); chk(rv == 8'h08, "R7 flip applied", rv, 8'h08);
    rd(164, rv); chk(rv == 8'h77, "R7 neighbour kept", rv, 8'h77);
    run(24'h5A2BD4, 24'h0, 0);
    rd(165, rv); chk(rv == 8'h08, "R7 no fix when disabled", rv, 8'h08);

    // R3 corrupted ECC with fix enabled leaves buffer
    run(24'h000001, 24'h0, 1);
    chk(result == 3'd2, "R3 code", result, 2);
    rd(0, rv); chk(rv == 8'h3C, "R3 buffer untouched", rv, 8'h3C);
    run(24'h000003, 24'h0, 1);
    rd(0, rv); chk(rv == 8'h3C, "R7 uncorrectable untouched", rv, 8'h3C);
    run(24'h0F00FF, 24'h0, 1);
    rd(0, rv); chk(rv == 8'h3D, "R7 bit0 byte0 flip", rv, 8'h3D);

    // R9 reset mid-state
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(result == 0 && err_byte == 0 && err_bit == 0, "R9 reset clears", {result, err_byte}, 0);
    rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule